// File: doc/BRIEF.md
# Accumulator ALU with Split-Edge Registers

This block is a 32-bit arithmetic and logic unit paired with an accumulator. A 4-bit opcode selects one of ten operations. Each operation combines the accumulator with a data operand, or transforms the data operand alone. The chosen result is registered on the rising edge of the execution clock.

An accumulator register captures that registered result on the following falling edge when its load enable is high. The accumulator feeds back as the accumulator operand for the next rising edge. One full clock period therefore computes and retires one operation, and a chain of accumulating operations runs back to back.

An active-low reset clears both registers at once and holds them at zero. Instruction sequencing and memory lie outside the block.

Top module: `opalu_acc`

## Requirements
- R1: Opcode 4'b0000 yields accumulator + data and opcode 4'b0001 yields accumulator - data, both wrapping modulo 2^32 with no carry output.
- R2: Opcode 4'b0010 yields data + 1 and opcode 4'b0011 yields data - 1, wrapping modulo 2^32 (all-ones + 1 gives zero, zero - 1 gives all-ones).
- R3: Opcodes 4'b0100, 4'b0101 and 4'b0110 yield the bitwise AND, OR and XOR of accumulator and data respectively.
- R4: Opcode 4'b0111 yields the bitwise inverse of data.
- R5: Opcode 4'b1000 yields data shifted left by one and opcode 4'b1001 yields data shifted right by one, the vacated bit filled with zero.
- R6: Opcodes 4'b1010 through 4'b1111 yield the accumulator value unchanged, so reloading leaves the accumulator as it was.
- R7: The ALU output changes only at a rising edge of the execution clock and holds its value across the falling edge.
- R8: On a falling edge with reset high, the accumulator takes the ALU output if the load enable is high and keeps its value if the load enable is low.
- R9: While reset is low, the accumulator and the ALU output are zero, immediately and regardless of clock or load enable.
- R10: The accumulator operand used at a rising edge is the accumulator value loaded at the preceding falling edge, so chained operations accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exec_clk | input | 1 | Execution clock; rising edge registers the ALU result, falling edge loads the accumulator |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| acc_load | input | 1 | Accumulator load enable, sampled on the falling edge |
| opcode | input | 4 | Operation select |
| operand | input | 32 | Data operand |
| alu_out | output | 32 | Registered ALU result |
| acc_out | output | 32 | Accumulator value |

## Verification
The accumulator load on a falling edge and the ALU capture on the next rising edge fall in the same clock period. In that period the just-loaded value becomes the ALU's own operand. The bench provokes this with runs of back-to-back accumulator-based operations with the load enable held high, including wrap-around sums and a pass-through reload. It judges each period against a behavioural model that updates its ALU value at the rise and its accumulator at the fall. Both outputs are checked a quarter period after each edge, so a mis-ordered or same-edge implementation shows a stale or premature value.

// File: rtl/opalu_pkg.sv
package opalu_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD   = 4'b0000,
    OPC_SUB   = 4'b0001,
    OPC_INC   = 4'b0010,
    OPC_DEC   = 4'b0011,
    OPC_AND   = 4'b0100,
    OPC_OR    = 4'b0101,
    OPC_XOR   = 4'b0110,
    OPC_NOT   = 4'b0111,
    OPC_SHL   = 4'b1000,
    OPC_SHR   = 4'b1001
  } opc_e;

  // Operation classes brought out for observation.
  typedef enum logic [2:0] {
    CLS_ARITH = 3'd0,
    CLS_LOGIC = 3'd1,
    CLS_SHIFT = 3'd2,
    CLS_PASS  = 3'd3
  } opc_class_e;

  function automatic opc_class_e classify(input logic [OPC_W-1:0] op);
    if (op <= OPC_DEC)      classify = CLS_ARITH;
    else if (op <= OPC_NOT) classify = CLS_LOGIC;
    else if (op <= OPC_SHR) classify = CLS_SHIFT;
    else                    classify = CLS_PASS;
  endfunction

endpackage

// File: rtl/opalu_core.sv
module opalu_core
  import opalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [W-1:0]     acc_in,
  input  logic [W-1:0]     data_in,
  output logic [W-1:0]     result,
  output opc_class_e       op_class
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] f_arith(input logic [OPC_W-1:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] d);
    logic [W-1:0] lhs, rhs;
    logic         sub;
    lhs = (op == OPC_ADD || op == OPC_SUB) ? a : d;
    rhs = (op == OPC_ADD || op == OPC_SUB) ? d : ONE;
    sub = (op == OPC_SUB || op == OPC_DEC);
    f_arith = sub ? (lhs - rhs) : (lhs + rhs);
  endfunction

  function automatic logic [W-1:0] f_logic(input logic [OPC_W-1:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] d);
    unique case (op)
      OPC_AND: f_logic = a & d;
      OPC_OR:  f_logic = a | d;
      OPC_XOR: f_logic = a ^ d;
      default: f_logic = ~d;
    endcase
  endfunction

  function automatic logic [W-1:0] f_shift(input logic [OPC_W-1:0] op,
                                           input logic [W-1:0] d);
    f_shift = (op == OPC_SHL) ? {d[W-2:0], 1'b0} : {1'b0, d[W-1:1]};
  endfunction

  logic [W-1:0] arith_r, logic_r, shift_r;

  always_comb begin
    op_class = classify(opcode);
    arith_r  = f_arith(opcode, acc_in, data_in);
    logic_r  = f_logic(opcode, acc_in, data_in);
    shift_r  = f_shift(opcode, data_in);
    unique case (op_class)
      CLS_ARITH: result = arith_r;
      CLS_LOGIC: result = logic_r;
      CLS_SHIFT: result = shift_r;
      default:   result = acc_in;
    endcase
  end

endmodule

// File: rtl/opalu_rise_reg.sv
module opalu_rise_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/opalu_fall_reg.sv
module opalu_fall_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/opalu_acc.sv
module opalu_acc
  import opalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             exec_clk,
  input  logic             rst_n,
  input  logic             acc_load,
  input  logic [OPC_W-1:0] opcode,
  input  logic [W-1:0]     operand,
  output logic [W-1:0]     alu_out,
  output logic [W-1:0]     acc_out
);

  // Named internal events for observation.
  logic [W-1:0] alu_next;
  logic [W-1:0] acc_fb;
  opc_class_e   cur_class;

  assign acc_fb = acc_out;

  opalu_core #(.W(W)) u_core (
    .opcode   (opcode),
    .acc_in   (acc_fb),
    .data_in  (operand),
    .result   (alu_next),
    .op_class (cur_class)
  );

  opalu_rise_reg #(.W(W)) u_alu_reg (
    .clk   (exec_clk),
    .rst_n (rst_n),
    .d     (alu_next),
    .q     (alu_out)
  );

  opalu_fall_reg #(.W(W)) u_acc_reg (
    .clk   (exec_clk),
    .rst_n (rst_n),
    .en    (acc_load),
    .d     (alu_out),
    .q     (acc_out)
  );

endmodule

// File: rtl/opalu_acc_chk.sv
module opalu_acc_chk
  import opalu_pkg::*;
#(
  parameter int W = 32
) (
  input logic             exec_clk,
  input logic             rst_n,
  input logic             acc_load,
  input logic [OPC_W-1:0] opcode,
  input logic [W-1:0]     operand,
  input logic [W-1:0]     alu_out,
  input logic [W-1:0]     acc_out
);

  p_add_wrap_r1: assert property (@(posedge exec_clk) disable iff (!rst_n)
    (opcode == 4'b0000) |=> (alu_out == W'($past(acc_out) + $past(operand))));

  p_not_data_r4: assert property (@(posedge exec_clk) disable iff (!rst_n)
    (opcode == 4'b0111) |=> (alu_out == ~$past(operand)));

  p_shl_zero_fill_r5: assert property (@(posedge exec_clk) disable iff (!rst_n)
    (opcode == 4'b1000) |=> (alu_out[0] == 1'b0));

  p_pass_acc_r6: assert property (@(posedge exec_clk) disable iff (!rst_n)
    (opcode >= 4'b1010) |=> (alu_out == $past(acc_out)));

  p_acc_load_r8: assert property (@(negedge exec_clk) disable iff (!rst_n)
    acc_load |=> (acc_out == $past(alu_out)));

  p_acc_hold_r8: assert property (@(negedge exec_clk) disable iff (!rst_n)
    !acc_load |=> $stable(acc_out));

endmodule

bind opalu_acc opalu_acc_chk #(.W(W)) u_chk (
  .exec_clk (exec_clk),
  .rst_n    (rst_n),
  .acc_load (acc_load),
  .opcode   (opcode),
  .operand  (operand),
  .alu_out  (alu_out),
  .acc_out  (acc_out)
);

// File: tb/opalu_acc_tb_top.sv
module opalu_acc_tb_top;

  logic        exec_clk = 1'b0;
  logic        rst_n    = 1'b0;
  logic        acc_load = 1'b0;
  logic [3:0]  opcode   = 4'd0;
  logic [31:0] operand  = 32'd0;
  logic [31:0] alu_out, acc_out;

  int tests = 0;
  int fails = 0;

  // Behavioural model state.
  longint m_alu = 0;
  longint m_acc = 0;

  always #10 exec_clk = ~exec_clk;

  opalu_acc dut_i (
    .exec_clk (exec_clk),
    .rst_n    (rst_n),
    .acc_load (acc_load),
    .opcode   (opcode),
    .operand  (operand),
    .alu_out  (alu_out),
    .acc_out  (acc_out)
  );

  localparam longint MOD = 64'h1_0000_0000;

  function automatic longint ref_op(input int op, input longint a, input longint d);
    longint r;
    case (op)
      0:  r = (a + d) % MOD;
      1:  r = (a + MOD - d) % MOD;
      2:  r = (d + 1) % MOD;
      3:  r = (d + MOD - 1) % MOD;
      4:  r = a & d;
      5:  r = a | d;
      6:  r = a ^ d;
      7:  r = (MOD - 1) - d;
      8:  r = (d * 2) % MOD;
      9:  r = d / 2;
      default: r = a;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Called in the low phase; runs one full period and checks after each edge.
  task automatic step(input int op, input longint d, input bit ld, input string req);
    opcode   = op[3:0];
    operand  = d[31:0];
    acc_load = ld;
    @(posedge exec_clk);
    m_alu = ref_op(op, m_acc, d);
    #5;
    check({req, " alu after rise"}, longint'(alu_out), m_alu);
    @(negedge exec_clk);
    if (ld) m_acc = m_alu;
    #5;
    check("R7 alu stable over fall", longint'(alu_out), m_alu);
    check({req, " R8 acc after fall"}, longint'(acc_out), m_acc);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #15;
    check("R9 reset alu", longint'(alu_out), 0);
    check("R9 reset acc", longint'(acc_out), 0);
    @(negedge exec_clk); #5;
    rst_n = 1'b1;

    // R10 chained accumulation, R1 add
    step(2, 32'h0000_0004, 1, "R2 inc");
    step(0, 32'h0000_0010, 1, "R1 R10 add chain");
    step(0, 32'h0000_0100, 1, "R1 R10 add chain");
    step(1, 32'h0000_0015, 1, "R1 sub");
    // R1 wrap
    step(2, 64'hFFFF_FFFE, 1, "R2 inc to all-ones");
    step(0, 32'h0000_0001, 1, "R1 add wrap");
    step(1, 32'h0000_0001, 1, "R1 sub wrap");
    // R2 wrap
    step(2, 64'hFFFF_FFFF, 0, "R2 inc wrap");
    step(3, 32'h0000_0000, 0, "R2 dec wrap");
    // R3 logic with acc = all-ones then pattern
    step(2, 64'hA5A5_5A5A, 1, "R2 load pattern");
    step(4, 64'h0FF0_F00F, 0, "R3 and");
    step(5, 64'h0FF0_F00F, 0, "R3 or");
    step(6, 64'h0FF0_F00F, 0, "R3 xor");
    step(4, 64'hFFFF_0000, 1, "R3 and load");
    // R4
    step(7, 64'h1234_5678, 0, "R4 not");
    step(7, 32'h0000_0000, 0, "R4 not zero");
    // R5
    step(8, 64'h8000_0001, 0, "R5 shl");
    step(9, 64'h8000_0001, 0, "R5 shr");
    step(8, 64'hFFFF_FFFF, 0, "R5 shl ones");
    step(9, 64'hFFFF_FFFF, 0, "R5 shr ones");
    // R6 pass-through for every spare opcode, reloading
    for (int op = 10; op < 16; op++) step(op, 64'hDEAD_BEEF, 1, "R6 pass");
    // R8 hold with load low
    step(0, 32'h0000_0777, 0, "R8 hold");
    step(0, 32'h0000_0001, 0, "R8 hold");
    step(0, 32'h0000_0001, 1, "R8 load");
    // R9 asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check("R9 async clear alu", longint'(alu_out), 0);
    check("R9 async clear acc", longint'(acc_out), 0);
    acc_load = 1'b1; opcode = 4'd2; operand = 32'h55;
    @(posedge exec_clk); #5;
    check("R9 alu held in reset", longint'(alu_out), 0);
    @(negedge exec_clk); #5;
    check("R9 acc held in reset", longint'(acc_out), 0);
    m_alu = 0; m_acc = 0;
    rst_n = 1'b1;
    step(0, 32'h0000_0003, 1, "R9 R10 after reset");
    step(0, 32'h0000_0003, 1, "R10 chain");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule